// File: doc/BRIEF.md
# Sv39 Translation Lookaside Buffer with Accessed/Dirty Control

This block caches Sv39 address translations in a small fully associative array that sits in front of a page table walker. A lookup presents a 39-bit virtual address, an address space identifier and a read/write flag. One cycle later the block answers with a physical address on a hit or a miss status otherwise. After a miss, the walker hands its finished result (leaf PTE, PTE location, leaf level, global flag and translated address) back to the block, which installs it. Each entry keeps the leaf level, and the level sets how many low address bits pass straight through. Pages of 4 KiB, 2 MiB and 1 GiB therefore live side by side in the same array.

Before a translation is used, the block checks whether the leaf PTE needs its accessed or dirty flag set. A control input selects the policy. With the control low, such an access is refused with an update-failure status. With the control high, the updated PTE goes out on a memory write port, and the cached copy is refreshed or installed only once the write succeeds. A flush input invalidates the whole array in one cycle.

Top module: `sv39_xlat_tlb`

## Requirements
- R1: After reset `ready_o` is 1, `resp_valid_o` and `mem_wr_valid_o` are 0, and every entry is invalid, so the first lookup misses.
- R2: An entry hits when it is valid, its stored virtual address equals the request address in all bits above the page-offset mask, and it is global or its ASID equals the request ASID. If several entries hit, the lowest index is used.
- R3: The page-offset mask is 2^(12+9*level)-1. A hit returns the stored physical address with its masked bits cleared, OR'd with the request address ANDed with the mask.
- R4: Each accepted lookup or walk result gives exactly one `resp_valid_o` pulse, one cycle after the decision. Status codes: 0 = ok, 1 = miss, 2 = update refused, 3 = write error. `resp_paddr_o` is 0 for every status other than ok. A miss returns status 1.
- R5: A walk result that needs no update is installed at a round-robin pointer. The pointer starts at 0 after reset and advances by one, modulo 8, on every install. The response is ok and carries the walk's physical address.
- R6: An update is needed when PTE bit 6 (accessed) is 0, or when the access is a write and PTE bit 7 (dirty) is 0. The updated PTE sets bit 6, and also sets bit 7 for a write.
- R7: With `ad_wb_en_i` low, an access that needs an update returns status 2. It installs nothing, changes no entry and issues no memory write.
- R8: With `ad_wb_en_i` high, a hit that needs an update drives `mem_wr_valid_o` with the entry's PTE address and the updated PTE, and holds them steady until `mem_wr_ack_i`. If the ack carries no error, the stored PTE is rewritten and the response is ok with the hit address. A repeat of the same access then needs no write.
- R9: With `ad_wb_en_i` high, a walk result that needs an update first writes the updated PTE to its address. The entry is installed only on an error-free ack. An ack with `mem_wr_err_i` returns status 3 and installs nothing.
- R10: `flush_i` invalidates all entries at the next edge. An install in the same cycle is also discarded.
- R11: When a walk result and a lookup arrive in the same cycle, the walk result is taken and the lookup is dropped. While `ready_o` is low, lookups and walk results are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| ad_wb_en_i | input | 1 | 1 = write back accessed/dirty updates, 0 = refuse them |
| ready_o | output | 1 | Block accepts a lookup or walk result this cycle |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 39 | Lookup virtual address |
| req_asid_i | input | 16 | Lookup ASID |
| req_write_i | input | 1 | Lookup is a write access |
| walk_valid_i | input | 1 | Walk result present |
| walk_vaddr_i | input | 39 | Virtual address that was walked |
| walk_asid_i | input | 16 | ASID of the walk |
| walk_write_i | input | 1 | Walked access is a write |
| walk_paddr_i | input | 56 | Translated physical address |
| walk_pte_i | input | 64 | Leaf PTE |
| walk_pte_addr_i | input | 56 | Physical address of the leaf PTE |
| walk_level_i | input | 2 | Leaf level (0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB) |
| walk_global_i | input | 1 | Leaf mapping is global |
| resp_valid_o | output | 1 | Response pulse |
| resp_status_o | output | 2 | Response status code |
| resp_paddr_o | output | 56 | Physical address on ok |
| mem_wr_valid_o | output | 1 | PTE write request |
| mem_wr_addr_o | output | 56 | PTE write address |
| mem_wr_data_o | output | 64 | Updated PTE |
| mem_wr_ack_i | input | 1 | PTE write completed |
| mem_wr_err_i | input | 1 | PTE write failed (valid with ack) |

## Verification
A corrupted mask, ASID or valid bit in one slot shows up at the very next lookup to that slot: the response one cycle later has the wrong status or wrong address bits. A wrong replacement pointer stays hidden until the array wraps, and then the wrong translation is evicted, so the round-robin sequence has to be run past eight installs. A bad update decision appears as a missing or spurious write request, or as a stale PTE that makes the same access write again. The bench compares status, address and write-port contents against a behavioural model on every clock, so the divergence is reported in the cycle it appears.

// File: rtl/sv39_tlb_pkg.sv
package sv39_tlb_pkg;
  localparam int VA_W      = 39;
  localparam int PA_W      = 56;
  localparam int PTE_W     = 64;
  localparam int ASID_W    = 16;
  localparam int LVL_W     = 2;
  localparam int PG_BITS   = 12;
  localparam int LVL_BITS  = 9;
  localparam int PTE_A_BIT = 6;
  localparam int PTE_D_BIT = 7;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_MISS     = 2'd1,
    RSP_UPD_FAIL = 2'd2,
    RSP_ACC_FAIL = 2'd3
  } rsp_e;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [VA_W-1:0]   va;
    logic [PA_W-1:0]   pa;
    logic [LVL_W-1:0]  lvl;
    logic [PTE_W-1:0]  pte;
    logic [PA_W-1:0]   pte_addr;
  } ent_t;

  // low bits passed through for a leaf at this level
  function automatic logic [VA_W-1:0] page_mask(input logic [LVL_W-1:0] lvl);
    logic [VA_W:0] m;
    m = ((VA_W+1)'(1) << (PG_BITS + LVL_BITS * int'(lvl))) - (VA_W+1)'(1);
    return m[VA_W-1:0];
  endfunction
endpackage

// File: rtl/tlb_ad_eval.sv
module tlb_ad_eval
  import sv39_tlb_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic             write_i,
  output logic             need_o,
  output logic [PTE_W-1:0] pte_o
);
  always_comb begin
    need_o = !pte_i[PTE_A_BIT] || (write_i && !pte_i[PTE_D_BIT]);
    pte_o  = pte_i;
    pte_o[PTE_A_BIT] = 1'b1;
    if (write_i) pte_o[PTE_D_BIT] = 1'b1;
  end
endmodule

// File: rtl/tlb_slot.sv
module tlb_slot
  import sv39_tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  ent_t              ld_ent_i,
  input  logic              pte_we_i,
  input  logic [PTE_W-1:0]  pte_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              hit_o,
  output ent_t              ent_o
);
  logic            vld_q;
  ent_t            ent_q;
  logic [VA_W-1:0] mask;
  logic            asid_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ent_q <= '0;
    end else begin
      if (ld_i)          ent_q     <= ld_ent_i;
      else if (pte_we_i) ent_q.pte <= pte_i;
      if (clr_i)         vld_q <= 1'b0;
      else if (ld_i)     vld_q <= 1'b1;
    end
  end

  // stored va is pre-masked, so only the tag bits take part
  assign mask    = page_mask(ent_q.lvl);
  assign asid_ok = ent_q.glob || (ent_q.asid == lk_asid_i);
  assign hit_o   = vld_q && asid_ok && ((lk_va_i & ~mask) == ent_q.va);
  assign ent_o   = ent_q;
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/sv39_xlat_tlb.sv
module sv39_xlat_tlb
  import sv39_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              ad_wb_en_i,
  output logic              ready_o,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [ASID_W-1:0] req_asid_i,
  input  logic              req_write_i,
  input  logic              walk_valid_i,
  input  logic [VA_W-1:0]   walk_vaddr_i,
  input  logic [ASID_W-1:0] walk_asid_i,
  input  logic              walk_write_i,
  input  logic [PA_W-1:0]   walk_paddr_i,
  input  logic [PTE_W-1:0]  walk_pte_i,
  input  logic [PA_W-1:0]   walk_pte_addr_i,
  input  logic [LVL_W-1:0]  walk_level_i,
  input  logic              walk_global_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_status_o,
  output logic [PA_W-1:0]   resp_paddr_o,
  output logic              mem_wr_valid_o,
  output logic [PA_W-1:0]   mem_wr_addr_o,
  output logic [PTE_W-1:0]  mem_wr_data_o,
  input  logic              mem_wr_ack_i,
  input  logic              mem_wr_err_i
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  typedef enum logic {ST_IDLE, ST_WB} state_e;

  state_e               state_q, state_d;
  logic [IDX_W-1:0]     rr_q, rr_d;
  logic                 wb_hit_q, wb_hit_d;
  logic [IDX_W-1:0]     wb_idx_q, wb_idx_d;
  ent_t                 wb_ent_q, wb_ent_d;
  logic [PA_W-1:0]      wb_pa_q, wb_pa_d;
  logic                 rsp_v_q, rsp_v_d;
  rsp_e                 rsp_st_q, rsp_st_d;
  logic [PA_W-1:0]      rsp_pa_q, rsp_pa_d;

  logic [N_ENTRIES-1:0] hits, ld_vec, pte_we_vec;
  ent_t                 ents [N_ENTRIES];
  logic                 any_hit;
  logic [IDX_W-1:0]     hit_idx;
  ent_t                 sel_ent, walk_ent, ld_ent;
  logic                 ld_any, pte_we_any;

  logic                 hit_need, walk_need;
  logic [PTE_W-1:0]     hit_pte_new, walk_pte_new;
  logic [VA_W-1:0]      hit_mask, walk_mask;
  logic [PA_W-1:0]      hit_pa;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    tlb_slot i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (flush_i),
      .ld_i      (ld_vec[g]),
      .ld_ent_i  (ld_ent),
      .pte_we_i  (pte_we_vec[g]),
      .pte_i     (wb_ent_q.pte),
      .lk_va_i   (req_vaddr_i),
      .lk_asid_i (req_asid_i),
      .hit_o     (hits[g]),
      .ent_o     (ents[g])
    );
  end

  tlb_pick #(.N(N_ENTRIES), .IDX_W(IDX_W)) i_pick (
    .hit_i (hits),
    .any_o (any_hit),
    .idx_o (hit_idx)
  );

  assign sel_ent  = ents[hit_idx];
  assign hit_mask = page_mask(sel_ent.lvl);
  assign hit_pa   = sel_ent.pa | PA_W'(req_vaddr_i & hit_mask);

  tlb_ad_eval i_ad_hit (
    .pte_i   (sel_ent.pte),
    .write_i (req_write_i),
    .need_o  (hit_need),
    .pte_o   (hit_pte_new)
  );

  tlb_ad_eval i_ad_walk (
    .pte_i   (walk_pte_i),
    .write_i (walk_write_i),
    .need_o  (walk_need),
    .pte_o   (walk_pte_new)
  );

  assign walk_mask = page_mask(walk_level_i);

  always_comb begin
    walk_ent.asid     = walk_asid_i;
    walk_ent.glob     = walk_global_i;
    walk_ent.va       = walk_vaddr_i & ~walk_mask;
    walk_ent.pa       = walk_paddr_i & ~PA_W'(walk_mask);
    walk_ent.lvl      = walk_level_i;
    walk_ent.pte      = walk_pte_new;
    walk_ent.pte_addr = walk_pte_addr_i;
  end

  always_comb begin
    state_d    = state_q;
    wb_hit_d   = wb_hit_q;
    wb_idx_d   = wb_idx_q;
    wb_ent_d   = wb_ent_q;
    wb_pa_d    = wb_pa_q;
    rsp_v_d    = 1'b0;
    rsp_st_d   = RSP_OK;
    rsp_pa_d   = '0;
    ld_any     = 1'b0;
    ld_ent     = walk_ent;
    pte_we_any = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (walk_valid_i) begin
          rsp_v_d = 1'b1;
          if (!walk_need) begin
            ld_any   = 1'b1;
            rsp_pa_d = walk_paddr_i;
          end else if (!ad_wb_en_i) begin
            rsp_st_d = RSP_UPD_FAIL;
          end else begin
            rsp_v_d  = 1'b0;
            state_d  = ST_WB;
            wb_hit_d = 1'b0;
            wb_ent_d = walk_ent;
            wb_pa_d  = walk_paddr_i;
          end
        end else if (req_valid_i) begin
          rsp_v_d = 1'b1;
          if (!any_hit) begin
            rsp_st_d = RSP_MISS;
          end else if (!hit_need) begin
            rsp_pa_d = hit_pa;
          end else if (!ad_wb_en_i) begin
            rsp_st_d = RSP_UPD_FAIL;
          end else begin
            rsp_v_d      = 1'b0;
            state_d      = ST_WB;
            wb_hit_d     = 1'b1;
            wb_idx_d     = hit_idx;
            wb_ent_d     = sel_ent;
            wb_ent_d.pte = hit_pte_new;
            wb_pa_d      = hit_pa;
          end
        end
      end
      ST_WB: begin
        if (mem_wr_ack_i) begin
          state_d = ST_IDLE;
          rsp_v_d = 1'b1;
          if (mem_wr_err_i) begin
            rsp_st_d = RSP_ACC_FAIL;
          end else begin
            rsp_pa_d = wb_pa_q;
            ld_ent   = wb_ent_q;
            if (wb_hit_q) pte_we_any = 1'b1;
            else          ld_any     = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ld_vec     = ld_any     ? (N_ENTRIES'(1) << rr_q)     : '0;
  assign pte_we_vec = pte_we_any ? (N_ENTRIES'(1) << wb_idx_q) : '0;

  always_comb begin
    rr_d = rr_q;
    if (ld_any) rr_d = (rr_q == IDX_W'(N_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rr_q     <= '0;
      wb_hit_q <= 1'b0;
      wb_idx_q <= '0;
      wb_ent_q <= '0;
      wb_pa_q  <= '0;
      rsp_v_q  <= 1'b0;
      rsp_st_q <= RSP_OK;
      rsp_pa_q <= '0;
    end else begin
      state_q  <= state_d;
      rr_q     <= rr_d;
      wb_hit_q <= wb_hit_d;
      wb_idx_q <= wb_idx_d;
      wb_ent_q <= wb_ent_d;
      wb_pa_q  <= wb_pa_d;
      rsp_v_q  <= rsp_v_d;
      rsp_st_q <= rsp_st_d;
      rsp_pa_q <= rsp_pa_d;
    end
  end

  assign ready_o        = (state_q == ST_IDLE);
  assign resp_valid_o   = rsp_v_q;
  assign resp_status_o  = rsp_st_q;
  assign resp_paddr_o   = rsp_pa_q;
  assign mem_wr_valid_o = (state_q == ST_WB);
  assign mem_wr_addr_o  = wb_ent_q.pte_addr;
  assign mem_wr_data_o  = wb_ent_q.pte;
endmodule

// File: rtl/sv39_xlat_tlb_chk.sv
module sv39_xlat_tlb_chk
  import sv39_tlb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             ad_wb_en_i,
  input logic             ready_o,
  input logic             req_valid_i,
  input logic             walk_valid_i,
  input logic             resp_valid_o,
  input logic [1:0]       resp_status_o,
  input logic [PA_W-1:0]  resp_paddr_o,
  input logic             mem_wr_valid_o,
  input logic [PA_W-1:0]  mem_wr_addr_o,
  input logic [PTE_W-1:0] mem_wr_data_o,
  input logic             mem_wr_ack_i,
  input logic             mem_wr_err_i
);
  assert_fail_no_pa_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && (resp_status_o != 2'd0) |-> resp_paddr_o == '0);

  assert_wr_sets_a_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o |-> mem_wr_data_o[PTE_A_BIT]);

  assert_no_wr_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !ad_wb_en_i |=> !mem_wr_valid_o);

  assert_wr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o && !mem_wr_ack_i |=>
      mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o));

  assert_acc_fail_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && (resp_status_o == 2'd3) |->
      $past(mem_wr_valid_o && mem_wr_ack_i && mem_wr_err_i));

  assert_flush_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) && ready_o && req_valid_i && !walk_valid_i |=>
      resp_valid_o && (resp_status_o == 2'd1));

  assert_busy_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && !mem_wr_ack_i |=> !resp_valid_o && !ready_o);
endmodule

bind sv39_xlat_tlb sv39_xlat_tlb_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flush_i        (flush_i),
  .ad_wb_en_i     (ad_wb_en_i),
  .ready_o        (ready_o),
  .req_valid_i    (req_valid_i),
  .walk_valid_i   (walk_valid_i),
  .resp_valid_o   (resp_valid_o),
  .resp_status_o  (resp_status_o),
  .resp_paddr_o   (resp_paddr_o),
  .mem_wr_valid_o (mem_wr_valid_o),
  .mem_wr_addr_o  (mem_wr_addr_o),
  .mem_wr_data_o  (mem_wr_data_o),
  .mem_wr_ack_i   (mem_wr_ack_i),
  .mem_wr_err_i   (mem_wr_err_i)
);

// File: tb/test_sv39_xlat_tlb.sv
module test_sv39_xlat_tlb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        ad_wb_en_i = 1'b0;
  logic        ready_o;
  logic        req_valid_i = 1'b0;
  logic [38:0] req_vaddr_i = '0;
  logic [15:0] req_asid_i = '0;
  logic        req_write_i = 1'b0;
  logic        walk_valid_i = 1'b0;
  logic [38:0] walk_vaddr_i = '0;
  logic [15:0] walk_asid_i = '0;
  logic        walk_write_i = 1'b0;
  logic [55:0] walk_paddr_i = '0;
  logic [63:0] walk_pte_i = '0;
  logic [55:0] walk_pte_addr_i = '0;
  logic [1:0]  walk_level_i = '0;
  logic        walk_global_i = 1'b0;
  logic        resp_valid_o;
  logic [1:0]  resp_status_o;
  logic [55:0] resp_paddr_o;
  logic        mem_wr_valid_o;
  logic [55:0] mem_wr_addr_o;
  logic [63:0] mem_wr_data_o;
  logic        mem_wr_ack_i = 1'b0;
  logic        mem_wr_err_i = 1'b0;

  sv39_xlat_tlb i_sv39_xlat_tlb (.*);

  always #10 clk_i = ~clk_i;

  int    n_chk = 0, n_fail = 0, cyc = 0, wait_cnt = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  // ---------------- reference model ----------------
  bit          m_v [8];
  logic [15:0] m_asid [8];
  bit          m_g [8];
  logic [38:0] m_va [8];
  logic [55:0] m_pa [8];
  int          m_lvl [8];
  logic [63:0] m_pte [8];
  logic [55:0] m_ptea [8];
  int          m_rr;
  bit          m_busy, m_wb_hit;
  int          m_wb_idx;
  logic [15:0] s_asid; bit s_g; logic [38:0] s_va; logic [55:0] s_pa, s_rpa, s_addr;
  int          s_lvl; logic [63:0] s_pte;
  bit          e_rv, e_mv, e_rdy;
  int          e_st;
  logic [55:0] e_pa, e_ma;
  logic [63:0] e_md;

  function automatic logic [38:0] fmask(int lvl);
    logic [39:0] t;
    t = (40'd1 << (12 + 9 * lvl)) - 40'd1;
    return t[38:0];
  endfunction

  function automatic bit needs(logic [63:0] p, bit wr);
    return (p[6] == 1'b0) || (wr && p[7] == 1'b0);
  endfunction

  function automatic logic [63:0] upd(logic [63:0] p, bit wr);
    return p | 64'h40 | (wr ? 64'h80 : 64'h0);
  endfunction

  task m_install(logic [15:0] a, bit g, logic [38:0] va, logic [55:0] pa, int lvl,
                 logic [63:0] p, logic [55:0] pta);
    m_v[m_rr] = 1; m_asid[m_rr] = a; m_g[m_rr] = g; m_va[m_rr] = va; m_pa[m_rr] = pa;
    m_lvl[m_rr] = lvl; m_pte[m_rr] = p; m_ptea[m_rr] = pta;
    m_rr = (m_rr + 1) % 8;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) m_v[i] = 0;
      m_rr = 0; m_busy = 0; e_rv = 0; e_st = 0; e_pa = '0; e_mv = 0; e_rdy = 1;
      e_ma = '0; e_md = '0;
    end else begin
      e_rv = 0; e_st = 0; e_pa = '0;
      if (!m_busy) begin
        if (walk_valid_i) begin
          if (!needs(walk_pte_i, walk_write_i)) begin
            m_install(walk_asid_i, walk_global_i, walk_vaddr_i, walk_paddr_i,
                      int'(walk_level_i), walk_pte_i, walk_pte_addr_i);
            e_rv = 1; e_pa = walk_paddr_i;
          end else if (!ad_wb_en_i) begin
            e_rv = 1; e_st = 2;
          end else begin
            m_busy = 1; m_wb_hit = 0;
            s_asid = walk_asid_i; s_g = walk_global_i; s_va = walk_vaddr_i;
            s_pa = walk_paddr_i; s_lvl = int'(walk_level_i);
            s_pte = upd(walk_pte_i, walk_write_i); s_addr = walk_pte_addr_i;
            s_rpa = walk_paddr_i;
          end
        end else if (req_valid_i) begin
          int hi;
          hi = -1;
          for (int i = 7; i >= 0; i--) begin
            logic [38:0] mk;
            mk = fmask(m_lvl[i]);
            if (m_v[i] && (((req_vaddr_i ^ m_va[i]) & ~mk) == '0) &&
                (m_g[i] || m_asid[i] == req_asid_i)) hi = i;
          end
          e_rv = 1;
          if (hi < 0) e_st = 1;
          else begin
            logic [38:0] mk;
            logic [55:0] hpa;
            mk  = fmask(m_lvl[hi]);
            hpa = (m_pa[hi] & ~{17'd0, mk}) | {17'd0, req_vaddr_i & mk};
            if (!needs(m_pte[hi], req_write_i)) e_pa = hpa;
            else if (!ad_wb_en_i) e_st = 2;
            else begin
              e_rv = 0; m_busy = 1; m_wb_hit = 1; m_wb_idx = hi;
              s_pte = upd(m_pte[hi], req_write_i); s_addr = m_ptea[hi]; s_rpa = hpa;
            end
          end
        end
      end else if (mem_wr_ack_i) begin
        m_busy = 0; e_rv = 1;
        if (mem_wr_err_i) e_st = 3;
        else begin
          e_pa = s_rpa;
          if (m_wb_hit) m_pte[m_wb_idx] = s_pte;
          else m_install(s_asid, s_g, s_va, s_pa, s_lvl, s_pte, s_addr);
        end
      end
      if (flush_i) for (int i = 0; i < 8; i++) m_v[i] = 0;
      e_mv = m_busy; e_rdy = !m_busy; e_ma = s_addr; e_md = s_pte;
    end
  end

  task chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  // per-cycle comparison, sampled away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(ready_o == e_rdy, "ready", 64'(ready_o), 64'(e_rdy));
      chk(resp_valid_o == e_rv, "resp_valid", 64'(resp_valid_o), 64'(e_rv));
      if (e_rv) begin
        chk(resp_status_o == 2'(e_st), "status", 64'(resp_status_o), 64'(e_st));
        chk(resp_paddr_o == e_pa, "paddr", 64'(resp_paddr_o), 64'(e_pa));
      end
      chk(mem_wr_valid_o == e_mv, "mem_wr_valid", 64'(mem_wr_valid_o), 64'(e_mv));
      if (e_mv) begin
        chk(mem_wr_addr_o == e_ma, "mem_wr_addr", 64'(mem_wr_addr_o), 64'(e_ma));
        chk(mem_wr_data_o == e_md, "mem_wr_data", mem_wr_data_o, e_md);
      end
    end
  end

  // memory responder: ack on the third cycle of a pending write
  bit mem_err = 1'b0;
  always @(negedge clk_i) begin
    if (mem_wr_valid_o && !mem_wr_ack_i) begin
      if (wait_cnt == 2) begin mem_wr_ack_i = 1'b1; mem_wr_err_i = mem_err; end
      else wait_cnt++;
    end else begin
      mem_wr_ack_i = 1'b0; mem_wr_err_i = 1'b0; wait_cnt = 0;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task wait_rdy();
    while (!ready_o) @(negedge clk_i);
  endtask

  task req(logic [38:0] va, logic [15:0] asid, bit wr);
    wait_rdy();
    req_valid_i = 1; req_vaddr_i = va; req_asid_i = asid; req_write_i = wr;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task walk(logic [38:0] va, logic [15:0] asid, bit wr, logic [55:0] pa, logic [63:0] pte,
            logic [55:0] pta, logic [1:0] lvl, bit g);
    wait_rdy();
    walk_valid_i = 1; walk_vaddr_i = va; walk_asid_i = asid; walk_write_i = wr;
    walk_paddr_i = pa; walk_pte_i = pte; walk_pte_addr_i = pta;
    walk_level_i = lvl; walk_global_i = g;
    @(negedge clk_i);
    walk_valid_i = 0;
  endtask

  task idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    cur_tag = "R1";
    idle(2);
    req(39'h00_1234_5000, 16'd5, 0);       // empty array: miss
    cur_tag = "R4";
    req(39'h00_0000_0000, 16'd0, 1);
    idle(1);

    // 4 KiB, 2 MiB and 1 GiB leaves
    cur_tag = "R5";
    walk(39'h00_1234_5678, 16'd5, 0, 56'h8_0000_A678, 64'hC1, 56'h1000, 2'd0, 0);
    walk(39'h00_4020_0000, 16'd5, 0, 56'h40_0000, 64'hC1, 56'h1008, 2'd1, 0);
    walk(39'h00_8000_0000, 16'd9, 0, 56'h1_4000_0000, 64'hC1, 56'h1010, 2'd2, 1);
    cur_tag = "R3";
    req(39'h00_1234_5ABC, 16'd5, 0);
    req(39'h00_4021_2345, 16'd5, 1);
    req(39'h00_BFFF_FFF8, 16'd9, 0);
    req(39'h00_8765_4321, 16'd5, 1);
    cur_tag = "R2";
    req(39'h00_1234_5ABC, 16'd6, 0);        // asid mismatch: miss
    req(39'h00_8000_0010, 16'd3, 0);        // global: hit any asid
    req(39'h00_4040_0000, 16'd5, 0);        // next 2M page: miss
    req(39'h00_C000_0000, 16'd9, 0);        // next 1G page: miss
    idle(1);

    // A/D handling disabled
    cur_tag = "R6";
    ad_wb_en_i = 0;
    walk(39'h00_0777_7000, 16'd5, 0, 56'h9_0000_0000, 64'h41, 56'h2000, 2'd0, 0);
    req(39'h00_0777_7010, 16'd5, 0);        // read, A=1: ok
    cur_tag = "R7";
    req(39'h00_0777_7010, 16'd5, 1);        // write, D=0: refused
    walk(39'h00_0666_6000, 16'd5, 0, 56'h9_1000_0000, 64'h01, 56'h2008, 2'd0, 0);
    req(39'h00_0666_6000, 16'd5, 0);        // not installed: miss
    req(39'h00_0777_7010, 16'd5, 0);        // entry unchanged
    idle(1);

    // A/D write-back on a hit
    cur_tag = "R8";
    ad_wb_en_i = 1;
    req(39'h00_0777_7020, 16'd5, 1);
    req(39'h00_0777_7030, 16'd5, 1);        // now D=1: no write
    idle(2);

    // A/D write-back on a walk result
    cur_tag = "R9";
    walk(39'h00_0666_6000, 16'd5, 1, 56'h9_1000_0000, 64'h01, 56'h2008, 2'd0, 0);
    req(39'h00_0666_6444, 16'd5, 1);
    mem_err = 1;
    walk(39'h00_0555_5000, 16'd5, 0, 56'h9_2000_0000, 64'h01, 56'h2010, 2'd0, 0);
    req(39'h00_0555_5000, 16'd5, 0);        // write failed: miss
    mem_err = 0;
    idle(1);

    // priority and busy behaviour
    cur_tag = "R11";
    wait_rdy();
    walk_valid_i = 1; walk_vaddr_i = 39'h00_0444_4000; walk_asid_i = 16'd5;
    walk_write_i = 0; walk_paddr_i = 56'h9_3000_0000; walk_pte_i = 64'hC1;
    walk_pte_addr_i = 56'h2018; walk_level_i = 2'd0; walk_global_i = 0;
    req_valid_i = 1; req_vaddr_i = 39'h00_1234_5000; req_asid_i = 16'd5; req_write_i = 0;
    @(negedge clk_i);
    walk_valid_i = 0; req_valid_i = 0;
    walk(39'h00_0333_3000, 16'd5, 0, 56'h9_4000_0000, 64'h01, 56'h2020, 2'd0, 0);
    req_valid_i = 1; req_vaddr_i = 39'h00_1234_5000; req_asid_i = 16'd5;
    walk_valid_i = 1; walk_vaddr_i = 39'h00_0222_2000; walk_pte_i = 64'hC1;
    @(negedge clk_i);
    req_valid_i = 0; walk_valid_i = 0;
    req(39'h00_0222_2000, 16'd5, 0);        // ignored walk: miss
    req(39'h00_0444_4000, 16'd5, 0);
    idle(2);

    // flush
    cur_tag = "R10";
    wait_rdy();
    flush_i = 1; @(negedge clk_i); flush_i = 0;
    req(39'h00_1234_5000, 16'd5, 0);
    req(39'h00_8000_0000, 16'd9, 0);
    wait_rdy();
    flush_i = 1;
    walk(39'h00_0111_1000, 16'd5, 0, 56'h9_5000_0000, 64'hC1, 56'h2028, 2'd0, 0);
    flush_i = 0;
    req(39'h00_0111_1000, 16'd5, 0);
    idle(1);

    // round-robin wrap and duplicate priority
    cur_tag = "R5";
    for (int i = 0; i < 9; i++)
      walk(39'h10_0000_0000 + 39'(i * 4096), 16'd7, 0, 56'hA_0000_0000 + 56'(i * 4096),
           64'hC1, 56'h3000 + 56'(i * 8), 2'd0, 0);
    for (int i = 0; i < 9; i++) req(39'h10_0000_0010 + 39'(i * 4096), 16'd7, 0);
    cur_tag = "R2";
    walk(39'h10_0000_2000, 16'd7, 0, 56'hB_0000_0000, 64'hC1, 56'h4000, 2'd0, 0);
    req(39'h10_0000_2020, 16'd7, 0);
    req(39'h10_0000_3020, 16'd7, 0);
    idle(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule